// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt events for a small 8-bit microcontroller core and decides when to interrupt the CPU. There are nine sources. Three are core sources: an external pin edge, a change on an input port, and a timer-0 overflow. Their flags and enables share the core control register with the global enable and the peripheral group enable. The other six are peripheral sources, with EEPROM write done, ADC done, serial port, capture/compare, timer-1 and timer-2. Their flags and enables sit in two registers of their own. Each peripheral source is masked by its own enable and then by the group enable. Every result is masked by the global enable before it reaches the CPU.

A source's flag sets whenever its event occurs, whatever the enables say. Hardware never clears a flag. Software clears it through the register port. The CPU sees `irq_req`. When it takes the vector it pulses `irq_ack`. The block then reports the push of the return address and the vector load to address 0x0004, and it clears the global enable. The return strobe `irq_ret` sets the global enable again. A wake-up output is taken ahead of the global gate, so a sleeping core still wakes while the global enable is clear.

The external pin and the port inputs are asynchronous. Each passes through a two-flop synchroniser. The resulting flag sets only at the clock edge that ends quarter-phase 3 of the instruction cycle. This makes the latency from a pin event to the request depend only on the phase in which the event arrives.

Top module: `two_level_irq`

## Requirements
- R1: A flag sets on its event even when its own enable, the group enable and the global enable are all clear. A `per_evt[i]` pulse sets peripheral flag bit i one cycle later. A `tmr0_ovf` pulse sets core flag bit 0 one cycle later.
- R2: A peripheral source counts as pending only when its flag bit, its enable bit (same index in address 2) and the group enable (core bit 6) are all set.
- R3: A core source counts as pending when its flag and enable are set, whatever the group enable holds.
- R4: `irq_req` is high exactly when the global enable (core bit 7) is set and at least one source is pending.
- R5: The register map is as follows. Address 0 is core control: bit 7 global enable, bit 6 group enable, bits 5/4/3 enables for port change/ext pin/timer-0, bits 2/1/0 flags for port change/ext pin/timer-0. Address 1 holds the peripheral flags in bits 5:0. Address 2 holds the peripheral enables in bits 5:0. Address 3 bit 0 selects the ext pin edge polarity (1 = rising). After reset, addresses 0–2 read 0 and address 3 reads 1.
- R6: While `irq_req` is high, `irq_ack` raises `push_ret` and `vec_load` in the same cycle, with `vec_addr` = 0x0004. The global enable is clear from the next cycle on. `irq_ack` takes priority over `irq_ret` and over a register write.
- R7: An `irq_ret` pulse without `irq_ack` sets the global enable from the next cycle on.
- R8: Hardware never clears a flag. A register write replaces the flag bits. If a hardware set and a write meet in the same cycle, the set wins.
- R9: `wake` is high whenever at least one source is pending, independent of the global enable.
- R10: An external pin or port change event sets its flag only at the clock edge that closes a cycle with `q_phase` = 3. That edge is the first one at least two edges after the input changes.
- R11: With address 3 bit 0 clear, only falling edges of `ext_pin` set the ext flag. With it set, only rising edges do.
- R12: A port change is any difference between the synchronised `port_in` and a snapshot that is taken on each read of address 0. The event keeps recurring until such a read matches the snapshot to the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_phase | input | 2 | Quarter-phase of the current instruction cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | PW | Asynchronous port inputs watched for change |
| tmr0_ovf | input | 1 | Timer-0 overflow pulse |
| per_evt | input | NP | Peripheral event pulses |
| irq_ack | input | 1 | CPU takes the vector |
| irq_ret | input | 1 | CPU return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-up request, not gated by the global enable |
| push_ret | output | 1 | Push the return address |
| vec_load | output | 1 | Load the program counter with `vec_addr` |
| vec_addr | output | VW | Interrupt vector address |

## Verification
The bench measures pin-to-request latency for each of the four arrival phases. A design that latched asynchronous events without the phase gate, or with a missing synchroniser stage, would give a cycle count that differs from the one computed for that phase. The bench also makes a hardware set collide with a software clear of the same flag. A design that let the write win would lose the event and read back a clear flag. Further directed cases check the group enable against the core sources, the wake output with the global enable clear, the ignored edge polarity and the port snapshot taken on read. A design that gated wake through the global enable, or masked core sources with the group enable, would give the wrong level on `wake` or `irq_req`. Random register traffic mixed with event pulses, acknowledges and returns is compared each cycle against a reference model of the register state.

// File: rtl/two_level_irq.sv
module two_level_irq #(
  parameter int PW = 4,
  parameter int NP = 6,
  parameter int VW = 13,
  parameter logic [VW-1:0] VEC = 'h4,
  parameter int QS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    q_phase,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ext_pin,
  input  logic [PW-1:0] port_in,
  input  logic          tmr0_ovf,
  input  logic [NP-1:0] per_evt,
  input  logic          irq_ack,
  input  logic          irq_ret,
  output logic          irq_req,
  output logic          wake,
  output logic          push_ret,
  output logic          vec_load,
  output logic [VW-1:0] vec_addr
);
  localparam logic [1:0] A_CORE = 2'd0, A_PFLG = 2'd1, A_PEN = 2'd2, A_CFG = 2'd3;

  logic          gie, pge, rise_sel;
  logic [2:0]    cen, cflg;
  logic [NP-1:0] pflg, pen;
  logic [1:0]    ext_s;
  logic          ext_prev, ext_pend, prt_pend;
  logic [PW-1:0] p_s1, p_s2, p_snap;

  wire wr_core = reg_we && reg_addr == A_CORE;
  wire wr_pf   = reg_we && reg_addr == A_PFLG;
  wire wr_pe   = reg_we && reg_addr == A_PEN;
  wire wr_cfg  = reg_we && reg_addr == A_CFG;

  wire ext_edge = rise_sel ? (ext_s[1] & ~ext_prev) : (~ext_s[1] & ext_prev);
  wire prt_diff = |(p_s2 ^ p_snap);
  wire at_q     = q_phase == 2'(QS);
  wire [2:0] hw_set = {at_q & (prt_pend | prt_diff), at_q & (ext_pend | ext_edge), tmr0_ovf};

  wire core_hit = |(cflg & cen);
  wire per_hit  = pge & |(pflg & pen);

  assign wake     = core_hit | per_hit;
  assign irq_req  = gie & wake;
  assign push_ret = irq_ack & irq_req;
  assign vec_load = push_ret;
  assign vec_addr = VEC;

  always_comb begin
    case (reg_addr)
      A_CORE:  reg_rdata = {gie, pge, cen, cflg};
      A_PFLG:  reg_rdata = 8'(pflg);
      A_PEN:   reg_rdata = 8'(pen);
      default: reg_rdata = {7'b0, rise_sel};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      pge      <= 1'b0;
      cen      <= '0;
      cflg     <= '0;
      pflg     <= '0;
      pen      <= '0;
      rise_sel <= 1'b1;
      ext_s    <= '0;
      ext_prev <= 1'b0;
      ext_pend <= 1'b0;
      prt_pend <= 1'b0;
      p_s1     <= '0;
      p_s2     <= '0;
      p_snap   <= '0;
    end else begin
      ext_s    <= {ext_s[0], ext_pin};
      ext_prev <= ext_s[1];
      p_s1     <= port_in;
      p_s2     <= p_s1;
      ext_pend <= at_q ? 1'b0 : (ext_pend | ext_edge);
      prt_pend <= at_q ? 1'b0 : (prt_pend | prt_diff);
      if (reg_re && reg_addr == A_CORE) p_snap <= p_s2;

      cflg <= (wr_core ? reg_wdata[2:0] : cflg) | hw_set;
      pflg <= (wr_pf ? reg_wdata[NP-1:0] : pflg) | per_evt;
      if (wr_core) begin
        pge <= reg_wdata[6];
        cen <= reg_wdata[5:3];
      end
      if (wr_pe)  pen      <= reg_wdata[NP-1:0];
      if (wr_cfg) rise_sel <= reg_wdata[0];

      if (irq_ack)      gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (wr_core) gie <= reg_wdata[7];
    end
  end
endmodule

module two_level_irq_chk #(
  parameter int NP = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    q_phase,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic          irq_ack,
  input logic          irq_ret,
  input logic          irq_req,
  input logic          tmr0_ovf,
  input logic [NP-1:0] per_evt,
  input logic [NP-1:0] pflg,
  input logic [2:0]    cflg,
  input logic          gie
);
  p_ack_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_req);

  p_ret_sets_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> gie);

  p_ext_on_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cflg[1]) && !$past(reg_we && reg_addr == 2'd0)) |-> $past(q_phase) == 2'd3);

  p_tmr_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> cflg[0]);

  p_per_flag_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_evt) |=> ((pflg & $past(per_evt)) == $past(per_evt)));
endmodule

bind two_level_irq two_level_irq_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .reg_we(reg_we), .reg_addr(reg_addr),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .tmr0_ovf(tmr0_ovf),
  .per_evt(per_evt), .pflg(pflg), .cflg(cflg), .gie(gie)
);

// File: tb/sim_two_level_irq.sv
module sim_two_level_irq;
  localparam int PW = 4;
  localparam int NP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] q = 2'd0;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ext_pin = 0;
  logic [PW-1:0] port_in = 0;
  logic tmr0_ovf = 0;
  logic [NP-1:0] per_evt = 0;
  logic irq_ack = 0, irq_ret = 0;
  logic irq_req, wake, push_ret, vec_load;
  logic [12:0] vec_addr;

  always #4 clk = ~clk;
  always @(posedge clk) q <= q + 2'd1;

  two_level_irq #(.PW(PW), .NP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .q_phase(q), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_pin(ext_pin), .port_in(port_in), .tmr0_ovf(tmr0_ovf), .per_evt(per_evt),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .wake(wake),
    .push_ret(push_ret), .vec_load(vec_load), .vec_addr(vec_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int exp_lat(input logic [1:0] q0);
    for (int k = 2; k < 6; k++)
      if (((int'(q0) + k) % 4) == 3) return k + 1;
    return 0;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic wait_phase(input logic [1:0] q0);
    @(negedge clk);
    while (q != q0) @(negedge clk);
  endtask

  task automatic measure(input string tag, input int exp);
    int cnt = 0;
    while (!irq_req && cnt < 12) begin
      @(negedge clk);
      cnt++;
      #1;
    end
    check(tag, cnt, exp);
  endtask

  logic mgie, mpge, mrise;
  logic [2:0] mce, mcf;
  logic [NP-1:0] mpf, mpe;

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd19));
    repeat (3) @(negedge clk);
    #1;
    check("R5 reset irq_req", irq_req, 0);
    check("R5 reset wake", wake, 0);
    rst_n = 1;
    rd(0, d); check("R5 reset core", d, 8'h00);
    rd(1, d); check("R5 reset pflags", d, 8'h00);
    rd(2, d); check("R5 reset pen", d, 8'h00);
    rd(3, d); check("R5 reset polarity", d, 8'h01);

    // R1: flags set with every enable clear
    @(negedge clk); per_evt = 6'h21; tmr0_ovf = 1;
    @(negedge clk); per_evt = 0; tmr0_ovf = 0;
    #1 check("R1 no request", irq_req, 0);
    rd(1, d); check("R1 peripheral flags", d, 8'h21);
    rd(0, d); check("R1 timer flag", d, 8'h01);

    // R8: write clears; hardware set wins over simultaneous clear
    wr(0, 8'h00); rd(0, d); check("R8 software clear", d, 8'h00);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 8'h00; tmr0_ovf = 1;
    @(negedge clk); reg_we = 0; tmr0_ovf = 0;
    rd(0, d); check("R8 core set wins", d[0], 1);
    @(negedge clk); reg_we = 1; reg_addr = 1; reg_wdata = 8'h00; per_evt = 6'h08;
    @(negedge clk); reg_we = 0; per_evt = 0;
    rd(1, d); check("R8 peripheral set wins", d, 8'h08);

    // R2 / R3 gating
    wr(0, 8'h00); wr(1, 8'h04); wr(2, 8'h04); wr(0, 8'h80);
    #1 check("R2 group enable off", irq_req, 0);
    check("R2 wake group off", wake, 0);
    wr(0, 8'hC0); #1 check("R2 group enable on", irq_req, 1);
    wr(2, 8'h00); #1 check("R2 own enable off", irq_req, 0);
    wr(1, 8'h00);
    wr(0, 8'h89); #1 check("R3 core bypasses group", irq_req, 1);

    // R4 / R9: global gate, wake ahead of it
    wr(0, 8'h09); #1 check("R4 global off", irq_req, 0);
    check("R9 wake with global off", wake, 1);

    // R6 / R7: acknowledge and return
    wr(0, 8'h89);
    @(negedge clk); irq_ack = 1;
    #1 check("R6 push_ret", push_ret, 1);
    check("R6 vec_load", vec_load, 1);
    check("R6 vec_addr", vec_addr, 13'h0004);
    @(negedge clk); irq_ack = 0;
    #1 check("R6 global cleared", irq_req, 0);
    check("R9 wake after ack", wake, 1);
    rd(0, d); check("R8 flag kept after ack", d, 8'h09);
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
    #1 check("R7 global restored", irq_req, 1);

    // R10: ext pin latency per arrival phase, rising polarity
    for (int p = 0; p < 4; p++) begin
      ext_pin = 0;
      repeat (6) @(negedge clk);
      wr(0, 8'h90);
      wait_phase(2'(p));
      ext_pin = 1;
      measure($sformatf("R10 ext latency phase %0d", p), exp_lat(2'(p)));
    end
    ext_pin = 0;
    repeat (6) @(negedge clk);

    // R11: falling polarity
    wr(3, 8'h00); wr(0, 8'h90);
    ext_pin = 1;
    repeat (8) @(negedge clk);
    #1 check("R11 rising ignored", irq_req, 0);
    wait_phase(2'd2);
    ext_pin = 0;
    measure("R11 falling latency", exp_lat(2'd2));
    wr(3, 8'h01); wr(0, 8'h00);

    // R12: port change against snapshot
    wr(0, 8'hA0);
    wait_phase(2'd1);
    port_in = 4'h5;
    measure("R12 port latency", exp_lat(2'd1));
    repeat (4) @(negedge clk);
    rd(0, d);
    repeat (6) @(negedge clk);
    wr(0, 8'hA0);
    repeat (8) @(negedge clk);
    #1 check("R12 no change after snapshot", irq_req, 0);
    port_in = 4'h0;
    repeat (4) @(negedge clk);
    rd(0, d);
    repeat (6) @(negedge clk);

    // random traffic against model
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h01);
    mgie = 0; mpge = 0; mce = 0; mcf = 0; mpf = 0; mpe = 0; mrise = 1;
    for (int i = 0; i < 400; i++) begin
      logic mw, mirq;
      logic [7:0] er;
      @(negedge clk);
      reg_we = ($urandom % 3) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = 8'($urandom);
      tmr0_ovf = ($urandom % 5) == 0;
      per_evt = (($urandom % 4) == 0) ? NP'($urandom) : '0;
      irq_ack = ($urandom % 6) == 0;
      irq_ret = ($urandom % 6) == 0;
      #1;
      mw = (|(mcf & mce)) | (mpge & |(mpf & mpe));
      mirq = mgie & mw;
      case (reg_addr)
        2'd0: er = {mgie, mpge, mce, mcf};
        2'd1: er = 8'(mpf);
        2'd2: er = 8'(mpe);
        default: er = {7'b0, mrise};
      endcase
      check("R4 random irq_req", irq_req, mirq);
      check("R9 random wake", wake, mw);
      check("R6 random push_ret", push_ret, irq_ack & mirq);
      check("R5 random readback", reg_rdata, er);
      mcf = ((reg_we && reg_addr == 0) ? reg_wdata[2:0] : mcf) | {2'b00, tmr0_ovf};
      mpf = ((reg_we && reg_addr == 1) ? reg_wdata[NP-1:0] : mpf) | per_evt;
      if (reg_we && reg_addr == 0) begin mpge = reg_wdata[6]; mce = reg_wdata[5:3]; end
      if (reg_we && reg_addr == 2) mpe = reg_wdata[NP-1:0];
      if (reg_we && reg_addr == 3) mrise = reg_wdata[0];
      if (irq_ack) mgie = 0;
      else if (irq_ret) mgie = 1;
      else if (reg_we && reg_addr == 0) mgie = reg_wdata[7];
    end
    @(negedge clk);
    reg_we = 0; tmr0_ovf = 0; per_evt = 0; irq_ack = 0; irq_ret = 0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule